// File: doc/BRIEF.md
# Write-Through Sub-Blocked Data Cache

This block is the storage and lookup core of a first-level data cache. It is direct mapped, holds 16 KB by default, and splits each 32-byte line into two 16-byte halves, each with its own valid bit. The set is chosen from the virtual address. The hit decision compares the stored tag against a physical tag that the requester supplies with each access, because translation happens outside this block.

The pipeline presents one request per cycle, either a load or a store. A load gets a registered response one cycle later. The response carries a hit flag and a 64-bit word. A store never allocates a line. It updates the cached bytes only on a hit, and it is always passed on, one cycle later, on a write-through output toward the next level.

The next level returns one 16-byte half-line per fill. A coherence agent sends snoops that invalidate matching lines. Fills and snoops share a second tag port, so they never hold up a load's tag lookup issued in the same cycle.

Top module: `dcache_wt`

## Requirements
- R1: After reset every half-line valid bit is clear, so every load misses. `rsp_valid` and `wt_valid` are low while reset is asserted and in the first cycle after it.
- R2: Address decoding and hit rule.
  - `req_va[13:5]` selects the line, `req_va[4]` selects the half-line and `req_va[3]` selects the 64-bit word within it.
  - A load (`req_valid` with `req_we`=0) produces `rsp_valid` on the next cycle. `rsp_hit` is 1 only if the stored tag equals `req_ptag` and the addressed half-line is valid.
  - On a hit, `rsp_data` is bytes 8w..8w+7 of that half-line, where w is `req_va[3]`. Byte k of a half-line is byte k of the fill data.
  - `rsp_hit` is never high without `rsp_valid`.
- R3: A load that misses leaves every tag and valid bit unchanged.
- R4: A fill writes 16 bytes into half-line `fill_sub` of line `fill_line`, records `fill_ptag` as that line's tag and sets the half-line's valid bit.
  - If the line's old tag differs from `fill_ptag`, the other half-line's valid bit is cleared.
  - If the tags are equal, the other half-line's valid bit is kept.
- R5: A store that hits writes only those bytes of the addressed word whose `req_be` bit is set. Bit k of `req_be` enables byte k, which is `req_wdata[8k+7:8k]`. A store that misses leaves the line invalid.
- R6: Every store is forwarded to the write-through output, hit or miss, on the next cycle.
  - `wt_valid` is high for exactly that one cycle.
  - `wt_paddr` = {`req_ptag`, `req_va[12:0]`}, and `wt_data` and `wt_be` are copies of the store's data and byte mask.
- R7: A snoop whose `snp_ptag` matches the tag of line `snp_line` clears both of that line's valid bits. A snoop that does not match changes nothing.
- R8: A load issued in the same cycle as a matching snoop to the same line sees the state before the snoop.
- R9: Fills landing in the same cycle as a request.
  - A load issued in the same cycle as a fill to the same line sees the state before the fill.
  - A store issued in the same cycle as any fill does not change the cached data, but it is still forwarded as R6 requires.
- R10: When a matching snoop and a fill hit the same line in the same cycle, the snoop's clear takes effect first. Afterwards only the filled half-line is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Pipeline request this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_va | input | 14 | Virtual address: line index, half-line and word select |
| req_ptag | input | 28 | Physical tag of the access |
| req_wdata | input | 64 | Store data |
| req_be | input | 8 | Store byte enables |
| rsp_valid | output | 1 | Load response present |
| rsp_hit | output | 1 | Load hit |
| rsp_data | output | 64 | Load data word |
| fill_valid | input | 1 | Half-line fill this cycle |
| fill_line | input | 9 | Line index of the fill |
| fill_sub | input | 1 | Half-line of the fill |
| fill_ptag | input | 28 | Tag of the filled line |
| fill_data | input | 128 | Fill data, byte k at bits 8k+7:8k |
| snp_valid | input | 1 | Snoop this cycle |
| snp_line | input | 9 | Line index of the snoop |
| snp_ptag | input | 28 | Physical tag of the snoop |
| wt_valid | output | 1 | Forwarded store present |
| wt_paddr | output | 41 | Physical byte address of the forwarded store |
| wt_data | output | 64 | Forwarded store data |
| wt_be | output | 8 | Forwarded store byte enables |

## Verification
The assertions check the following on every cycle:
- a fill leaves its half-line valid;
- a matching snoop with no fill to the same line leaves the line fully invalid;
- a load miss with no fill or snoop present leaves its line's valid bits unchanged;
- the write-through output follows stores one for one, with the same address;
- a hit is only ever reported with a load response.

Only the bench's scenarios can show the data behaviour:
- that stored bytes merge correctly under a mask;
- that a tag change on a fill drops the sibling half-line;
- the ordering rules when a snoop or a fill coincides with a load, a store or each other.

// File: rtl/dc_cfg_pkg.sv
package dc_cfg_pkg;
  localparam int DEF_LINES      = 512;
  localparam int DEF_SUB_BYTES  = 16;
  localparam int DEF_WORD_BYTES = 8;
  localparam int DEF_PA_W       = 41;
  localparam int DEF_PGOFF_W    = 13;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int LINES  = 512,
  parameter int PTAG_W = 28,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  // port A: pipeline lookup
  input  logic              a_en,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic              a_sub,
  input  logic [PTAG_W-1:0] a_ptag,
  output logic              a_hit,
  // port B: snoop lookup and fill update
  input  logic              snp_en,
  input  logic [IDX_W-1:0]  snp_idx,
  input  logic [PTAG_W-1:0] snp_ptag,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic              fill_sub,
  input  logic [PTAG_W-1:0] fill_ptag
);
  logic [PTAG_W-1:0]     tag_mem [LINES];
  logic [LINES-1:0][1:0] vld_q;

  logic       snp_hit;
  logic [1:0] base_v;
  logic [1:0] fill_v;

  // port A: tag compare plus the addressed half-line valid bit
  assign a_hit = a_en && vld_q[a_idx][a_sub] && (tag_mem[a_idx] == a_ptag);

  // port B: snoop compare on any valid half-line
  assign snp_hit = snp_en && (vld_q[snp_idx] != 2'b00) && (tag_mem[snp_idx] == snp_ptag);

  // snoop clear is applied first, then the fill result
  always_comb begin
    base_v = vld_q[fill_idx];
    if (snp_hit && (snp_idx == fill_idx))
      base_v = 2'b00;
    fill_v = 2'b00;
    fill_v[fill_sub] = 1'b1;
    if (tag_mem[fill_idx] == fill_ptag)
      fill_v[~fill_sub] = base_v[~fill_sub];
  end

  // tag RAM: written only by port B fills
  always_ff @(posedge clk) begin
    if (fill_en)
      tag_mem[fill_idx] <= fill_ptag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (snp_hit)
        vld_q[snp_idx] <= 2'b00;
      if (fill_en)
        vld_q[fill_idx] <= fill_v;
    end
  end

  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> vld_q[$past(fill_idx)][$past(fill_sub)]); // R4

  AST_SNOOP_CLEARS_LINE: assert property (@(posedge clk) disable iff (rst)
    (snp_hit && !(fill_en && fill_idx == snp_idx)) |=> (vld_q[$past(snp_idx)] == 2'b00)); // R7

  AST_MISS_KEEPS_VALID: assert property (@(posedge clk) disable iff (rst)
    (a_en && !a_hit && !fill_en && !snp_en) |=> (vld_q[$past(a_idx)] == $past(vld_q[a_idx]))); // R3
endmodule

// File: rtl/dc_data_bank.sv
module dc_data_bank #(
  parameter int DEPTH  = 1024,
  parameter int BYTES  = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int DATA_W = 8 * BYTES
) (
  input  logic              clk,
  input  logic              we,
  input  logic [BYTES-1:0]  be,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // byte-enabled write, read-first synchronous read
  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < BYTES; b++) begin
        if (be[b])
          mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dc_wt_port.sv
module dc_wt_port #(
  parameter int PA_W   = 41,
  parameter int BE_W   = 8,
  localparam int WORD_W = 8 * BE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_en,
  input  logic [PA_W-1:0]   st_paddr,
  input  logic [WORD_W-1:0] st_data,
  input  logic [BE_W-1:0]   st_be,
  output logic              wt_valid,
  output logic [PA_W-1:0]   wt_paddr,
  output logic [WORD_W-1:0] wt_data,
  output logic [BE_W-1:0]   wt_be
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wt_valid <= 1'b0;
      wt_paddr <= '0;
      wt_data  <= '0;
      wt_be    <= '0;
    end else begin
      wt_valid <= st_en;
      if (st_en) begin
        wt_paddr <= st_paddr;
        wt_data  <= st_data;
        wt_be    <= st_be;
      end
    end
  end

  AST_WT_EVERY_STORE: assert property (@(posedge clk) disable iff (rst)
    st_en |=> (wt_valid && wt_paddr == $past(st_paddr))); // R6

  AST_WT_ONLY_STORES: assert property (@(posedge clk) disable iff (rst)
    !st_en |=> !wt_valid); // R6
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt #(
  parameter int LINES      = dc_cfg_pkg::DEF_LINES,
  parameter int SUB_BYTES  = dc_cfg_pkg::DEF_SUB_BYTES,
  parameter int WORD_BYTES = dc_cfg_pkg::DEF_WORD_BYTES,
  parameter int PA_W       = dc_cfg_pkg::DEF_PA_W,
  parameter int PGOFF_W    = dc_cfg_pkg::DEF_PGOFF_W,
  localparam int IDX_W     = $clog2(LINES),
  localparam int SUB_LSB   = $clog2(SUB_BYTES),
  localparam int LANE_LSB  = $clog2(WORD_BYTES),
  localparam int IDX_LSB   = SUB_LSB + 1,
  localparam int VA_W      = IDX_LSB + IDX_W,
  localparam int PTAG_W    = PA_W - PGOFF_W,
  localparam int LANES     = SUB_BYTES / WORD_BYTES,
  localparam int LANE_W    = $clog2(LANES),
  localparam int WORD_W    = 8 * WORD_BYTES,
  localparam int SUB_W     = 8 * SUB_BYTES,
  localparam int BANK_DEPTH = 2 * LINES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [VA_W-1:0]   req_va,
  input  logic [PTAG_W-1:0] req_ptag,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [WORD_BYTES-1:0] req_be,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WORD_W-1:0] rsp_data,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_line,
  input  logic              fill_sub,
  input  logic [PTAG_W-1:0] fill_ptag,
  input  logic [SUB_W-1:0]  fill_data,
  input  logic              snp_valid,
  input  logic [IDX_W-1:0]  snp_line,
  input  logic [PTAG_W-1:0] snp_ptag,
  output logic              wt_valid,
  output logic [PA_W-1:0]   wt_paddr,
  output logic [WORD_W-1:0] wt_data,
  output logic [WORD_BYTES-1:0] wt_be
);
  logic [IDX_W-1:0]  req_idx;
  logic              req_sub;
  logic [LANE_W-1:0] req_lane;
  logic              a_hit;
  logic              st_hit;
  logic              is_load;
  logic [IDX_W:0]    wr_addr;
  logic [IDX_W:0]    rd_addr;
  logic [LANE_W-1:0] lane_q;
  logic [WORD_W-1:0] rd_word [LANES];

  assign req_idx  = req_va[IDX_LSB +: IDX_W];
  assign req_sub  = req_va[SUB_LSB];
  assign req_lane = req_va[LANE_LSB +: LANE_W];
  assign is_load  = req_valid && !req_we;
  // a fill owns the data write port; a concurrent store only forwards
  assign st_hit   = req_valid && req_we && a_hit && !fill_valid;
  assign wr_addr  = fill_valid ? {fill_line, fill_sub} : {req_idx, req_sub};
  assign rd_addr  = {req_idx, req_sub};

  dc_tag_store #(.LINES(LINES), .PTAG_W(PTAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .a_en     (req_valid),
    .a_idx    (req_idx),
    .a_sub    (req_sub),
    .a_ptag   (req_ptag),
    .a_hit    (a_hit),
    .snp_en   (snp_valid),
    .snp_idx  (snp_line),
    .snp_ptag (snp_ptag),
    .fill_en  (fill_valid),
    .fill_idx (fill_line),
    .fill_sub (fill_sub),
    .fill_ptag(fill_ptag)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic                  bk_we;
    logic [WORD_BYTES-1:0] bk_be;
    logic [WORD_W-1:0]     bk_wd;

    assign bk_we = fill_valid || (st_hit && (req_lane == LANE_W'(g)));
    assign bk_be = fill_valid ? '1 : req_be;
    assign bk_wd = fill_valid ? fill_data[g*WORD_W +: WORD_W] : req_wdata;

    dc_data_bank #(.DEPTH(BANK_DEPTH), .BYTES(WORD_BYTES)) u_bank (
      .clk  (clk),
      .we   (bk_we),
      .be   (bk_be),
      .waddr(wr_addr),
      .wdata(bk_wd),
      .raddr(rd_addr),
      .rdata(rd_word[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      lane_q    <= '0;
    end else begin
      rsp_valid <= is_load;
      rsp_hit   <= is_load && a_hit;
      if (is_load)
        lane_q <= req_lane;
    end
  end

  assign rsp_data = rd_word[lane_q];

  dc_wt_port #(.PA_W(PA_W), .BE_W(WORD_BYTES)) u_wt (
    .clk     (clk),
    .rst     (rst),
    .st_en   (req_valid && req_we),
    .st_paddr({req_ptag, req_va[PGOFF_W-1:0]}),
    .st_data (req_wdata),
    .st_be   (req_be),
    .wt_valid(wt_valid),
    .wt_paddr(wt_paddr),
    .wt_data (wt_data),
    .wt_be   (wt_be)
  );

  AST_HIT_ONLY_WITH_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid); // R2
endmodule

// File: tb/dcache_wt_test.sv
module dcache_wt_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0, req_we = 1'b0;
  logic [13:0]  req_va = '0;
  logic [27:0]  req_ptag = '0;
  logic [63:0]  req_wdata = '0;
  logic [7:0]   req_be = '0;
  logic         rsp_valid, rsp_hit;
  logic [63:0]  rsp_data;
  logic         fill_valid = 1'b0;
  logic [8:0]   fill_line = '0;
  logic         fill_sub = 1'b0;
  logic [27:0]  fill_ptag = '0;
  logic [127:0] fill_data = '0;
  logic         snp_valid = 1'b0;
  logic [8:0]   snp_line = '0;
  logic [27:0]  snp_ptag = '0;
  logic         wt_valid;
  logic [40:0]  wt_paddr;
  logic [63:0]  wt_data;
  logic [7:0]   wt_be;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  dcache_wt uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_we(req_we), .req_va(req_va), .req_ptag(req_ptag),
    .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_sub(fill_sub),
    .fill_ptag(fill_ptag), .fill_data(fill_data),
    .snp_valid(snp_valid), .snp_line(snp_line), .snp_ptag(snp_ptag),
    .wt_valid(wt_valid), .wt_paddr(wt_paddr), .wt_data(wt_data), .wt_be(wt_be)
  );

  function automatic logic [13:0] mkva(input int line, input int sub, input int lane);
    mkva = {9'(line), 1'(sub), 1'(lane), 3'b000};
  endfunction

  task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0; fill_valid = 1'b0; snp_valid = 1'b0;
  endtask

  task automatic set_req(input logic we, input logic [13:0] va, input logic [27:0] ptag,
                         input logic [63:0] wd, input logic [7:0] be);
    req_valid = 1'b1; req_we = we; req_va = va; req_ptag = ptag; req_wdata = wd; req_be = be;
  endtask

  task automatic set_fill(input int line, input int sub, input logic [27:0] ptag,
                          input logic [127:0] d);
    fill_valid = 1'b1; fill_line = 9'(line); fill_sub = 1'(sub); fill_ptag = ptag; fill_data = d;
  endtask

  task automatic set_snp(input int line, input logic [27:0] ptag);
    snp_valid = 1'b1; snp_line = 9'(line); snp_ptag = ptag;
  endtask

  task automatic load_chk(input string req, input logic [13:0] va, input logic [27:0] ptag,
                          input logic exp_hit, input logic [63:0] exp_data);
    set_req(1'b0, va, ptag, '0, '0);
    tick();
    chk({req, " rsp_valid"}, 128'(rsp_valid), 128'(1'b1));
    chk({req, " rsp_hit"}, 128'(rsp_hit), 128'(exp_hit));
    if (exp_hit)
      chk({req, " rsp_data"}, 128'(rsp_data), 128'(exp_data));
  endtask

  task automatic do_fill(input int line, input int sub, input logic [27:0] ptag,
                         input logic [127:0] d);
    set_fill(line, sub, ptag, d);
    tick();
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid after reset", 128'(rsp_valid), 128'(1'b0));
    chk("R1 wt_valid after reset", 128'(wt_valid), 128'(1'b0));
    load_chk("R1 load after reset", mkva(0, 0, 0), 28'h0, 1'b0, '0);
    load_chk("R1 load line 5", mkva(5, 0, 0), 28'h0000123, 1'b0, '0);
  endtask

  task automatic t_fill_load();
    do_fill(5, 0, 28'h0000123, 128'hAAAAAAAA_AAAAAAAA_55555555_55555555);
    load_chk("R2 word0 hit", mkva(5, 0, 0), 28'h0000123, 1'b1, 64'h55555555_55555555);
    load_chk("R2 word1 hit", mkva(5, 0, 1), 28'h0000123, 1'b1, 64'hAAAAAAAA_AAAAAAAA);
    load_chk("R2 invalid half miss", mkva(5, 1, 0), 28'h0000123, 1'b0, '0);
    load_chk("R2 wrong tag miss", mkva(5, 0, 0), 28'h0000124, 1'b0, '0);
    // R3: the misses above must not have changed the line
    load_chk("R3 still hit after misses", mkva(5, 0, 1), 28'h0000123, 1'b1, 64'hAAAAAAAA_AAAAAAAA);
    load_chk("R3 still miss after misses", mkva(5, 1, 0), 28'h0000123, 1'b0, '0);
  endtask

  task automatic t_fill_policy();
    do_fill(6, 0, 28'h00000A0, 128'h11111111_11111111_10101010_10101010);
    do_fill(6, 1, 28'h00000A0, 128'h22222222_22222222_20202020_20202020);
    load_chk("R4 same tag keeps half0", mkva(6, 0, 0), 28'h00000A0, 1'b1, 64'h10101010_10101010);
    load_chk("R4 same tag half1", mkva(6, 1, 1), 28'h00000A0, 1'b1, 64'h22222222_22222222);
    do_fill(6, 0, 28'h00000B0, 128'h33333333_33333333_30303030_30303030);
    load_chk("R4 new tag half0", mkva(6, 0, 0), 28'h00000B0, 1'b1, 64'h30303030_30303030);
    load_chk("R4 new tag drops half1", mkva(6, 1, 0), 28'h00000B0, 1'b0, '0);
    load_chk("R4 old tag gone", mkva(6, 1, 0), 28'h00000A0, 1'b0, '0);
  endtask

  task automatic t_store();
    logic [13:0] va;
    va = mkva(5, 0, 0);
    set_req(1'b1, va, 28'h0000123, 64'h01234567_89ABCDEF, 8'h0F);
    tick();
    chk("R6 wt_valid on hit store", 128'(wt_valid), 128'(1'b1));
    chk("R6 wt_paddr", 128'(wt_paddr), 128'({28'h0000123, va[12:0]}));
    chk("R6 wt_data", 128'(wt_data), 128'(64'h01234567_89ABCDEF));
    chk("R6 wt_be", 128'(wt_be), 128'(8'h0F));
    chk("R6 no response for store", 128'(rsp_valid), 128'(1'b0));
    tick();
    chk("R6 wt_valid one cycle", 128'(wt_valid), 128'(1'b0));
    load_chk("R5 masked merge", mkva(5, 0, 0), 28'h0000123, 1'b1, 64'h55555555_89ABCDEF);
    load_chk("R5 other word untouched", mkva(5, 0, 1), 28'h0000123, 1'b1, 64'hAAAAAAAA_AAAAAAAA);
    va = mkva(5, 1, 1);
    set_req(1'b1, va, 28'h0000123, 64'hDEADBEEF_CAFEF00D, 8'hFF);
    tick();
    chk("R6 wt_valid on miss store", 128'(wt_valid), 128'(1'b1));
    chk("R6 wt_paddr miss store", 128'(wt_paddr), 128'({28'h0000123, va[12:0]}));
    load_chk("R5 miss store no allocate", va, 28'h0000123, 1'b0, '0);
  endtask

  task automatic t_snoop();
    do_fill(7, 0, 28'h00000C0, 128'h44444444_44444444_40404040_40404040);
    do_fill(7, 1, 28'h00000C0, 128'h55555555_55555555_50505050_50505050);
    set_snp(7, 28'h00000D0);
    tick();
    load_chk("R7 mismatched snoop no effect", mkva(7, 1, 0), 28'h00000C0, 1'b1, 64'h50505050_50505050);
    set_snp(7, 28'h00000C0);
    set_req(1'b0, mkva(7, 0, 1), 28'h00000C0, '0, '0);
    tick();
    chk("R8 load with snoop rsp_hit", 128'(rsp_hit), 128'(1'b1));
    chk("R8 load with snoop rsp_data", 128'(rsp_data), 128'(64'h44444444_44444444));
    load_chk("R7 snoop clears half0", mkva(7, 0, 0), 28'h00000C0, 1'b0, '0);
    load_chk("R7 snoop clears half1", mkva(7, 1, 0), 28'h00000C0, 1'b0, '0);
  endtask

  task automatic t_fill_collide();
    set_fill(8, 0, 28'h00000E0, 128'h66666666_66666666_60606060_60606060);
    set_req(1'b0, mkva(8, 0, 0), 28'h00000E0, '0, '0);
    tick();
    chk("R9 load with fill sees pre-fill", 128'(rsp_hit), 128'(1'b0));
    load_chk("R9 hit after fill", mkva(8, 0, 0), 28'h00000E0, 1'b1, 64'h60606060_60606060);
    set_fill(8, 1, 28'h00000E0, 128'h77777777_77777777_70707070_70707070);
    set_req(1'b1, mkva(8, 0, 0), 28'h00000E0, 64'hFFFFFFFF_FFFFFFFF, 8'hFF);
    tick();
    chk("R9 store with fill still forwarded", 128'(wt_valid), 128'(1'b1));
    load_chk("R9 store with fill not written", mkva(8, 0, 0), 28'h00000E0, 1'b1, 64'h60606060_60606060);
    load_chk("R9 concurrent fill landed", mkva(8, 1, 1), 28'h00000E0, 1'b1, 64'h77777777_77777777);
  endtask

  task automatic t_snoop_fill();
    do_fill(9, 0, 28'h00000F0, 128'h88888888_88888888_80808080_80808080);
    do_fill(9, 1, 28'h00000F0, 128'h99999999_99999999_90909090_90909090);
    set_snp(9, 28'h00000F0);
    set_fill(9, 0, 28'h00000F0, 128'hBBBBBBBB_BBBBBBBB_B0B0B0B0_B0B0B0B0);
    tick();
    load_chk("R10 filled half valid", mkva(9, 0, 0), 28'h00000F0, 1'b1, 64'hB0B0B0B0_B0B0B0B0);
    load_chk("R10 other half cleared", mkva(9, 1, 0), 28'h00000F0, 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill_load();
    t_fill_policy();
    t_store();
    t_snoop();
    t_fill_collide();
    t_snoop_fill();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule